// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the sticky status flags of an I2C controller and presents them as one 8-bit read-only status byte. The bus engine sends it single-cycle event strobes: the controller issued a start, a start was seen on the bus, a stop was seen on the bus, arbitration was lost, and the eighth rising clock edge of the address byte together with the received address. A release-bus command pulse, an interface-enable level and a read strobe also act on the flags.

Three bits are held here: the master-busy flag, the arbitration-lost flag and the extension-code flag. Each has its own set and clear events. The five low bits are live status inputs that are passed straight through to the output. A synchronous reset clears all of the held state.

Top module: `i2c_stat_reg`

## Requirements
- R1: After a synchronous reset, with all live inputs at 0, `stat_o` reads 8'h00. The bit layout is [7] master-busy, [6] arbitration-lost, [5] extension-code, [4:0] live inputs.
- R2: A controller-issued start (`start_gen_i`) sets master-busy at the next clock edge, provided no clear event for that flag occurs in the same cycle.
- R3: Master-busy clears at the next edge after a detected stop, an arbitration loss or a release command. When a clear and a set fall in the same cycle, the clear wins.
- R4: An arbitration loss sets arbitration-lost and clears master-busy at the same edge.
- R5: A read (`rd_i`) clears arbitration-lost at the following edge. The byte returned during that read still shows bit 6 = 1. An arbitration loss in the same cycle as a read leaves the flag at 1.
- R6: Extension-code sets at the edge where `bit8_rise_i` is high and `rx_addr_i[7:4]` is 4'b0000 or 4'b1111. Any other top nibble leaves the flag unchanged.
- R7: Extension-code clears at the next edge after a detected start, a detected stop or a release command. Clear wins over a set in the same cycle.
- R8: A falling `en_i`, detected against a registered copy of the previous enable, clears all three held flags. While `en_i` is low they stay 0 whatever events arrive.
- R9: `stat_o[4:0]` follows `live_i[4:0]` in the same cycle, with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Interface enable level |
| start_gen_i | input | 1 | Controller issued a start condition (pulse) |
| start_det_i | input | 1 | Start condition seen on the bus (pulse) |
| stop_det_i | input | 1 | Stop condition seen on the bus (pulse) |
| arb_lost_i | input | 1 | Arbitration lost (pulse) |
| bit8_rise_i | input | 1 | Eighth clock rising edge of the address byte (pulse) |
| rx_addr_i | input | ADDR_W | Received address byte |
| rel_i | input | 1 | Release-bus command (pulse) |
| rd_i | input | 1 | Status register read strobe |
| live_i | input | 5 | Live status bits, passed through to [4:0] |
| stat_o | output | 8 | Status byte |

## Verification
The arbitration-lost flag can receive its set event (a new loss) and its read-to-clear in the same cycle. This collision is the one where the set has priority. The bench provokes it in a directed sequence and again at random, with read and loss strobes that overlap. It judges the result from the flag value one edge later and from the byte returned during the read, which must still show the flag. The same-cycle conflicts on the other flags, where a set meets a clear (start issued together with a stop, a match on the eighth clock together with a detected start), are scored against a bench model in which the clear wins.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int LIVE_W  = 5;
  localparam int NIB_W   = 4;
  localparam int BIT_MST = 7;
  localparam int BIT_ARB = 6;
  localparam int BIT_EXT = 5;

  // Reserved-address nibble: all zeros or all ones.
  function automatic logic is_ext_nibble(input logic [NIB_W-1:0] nib);
    return (nib == {NIB_W{1'b0}}) || (nib == {NIB_W{1'b1}});
  endfunction
endpackage

// File: rtl/stat_en_edge.sv
module stat_en_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic en_fall_o
);
  logic en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) en_q <= 1'b0;
    else       en_q <= en_i;
  end

  assign en_fall_o = en_q & ~en_i;

  // R8: a fall is only reported when the enable really was high last cycle
  p_fall_prev_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    en_fall_o |-> ($past(en_i) && !en_i));
endmodule

// File: rtl/stat_sticky.sv
module stat_sticky #(
  parameter bit SET_BEATS_SOFT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic soft_clr_i,
  input  logic hard_clr_i,
  output logic q_o
);
  logic q;

  generate
    if (SET_BEATS_SOFT) begin : g_set_first
      always_ff @(posedge clk_i) begin
        if (rst_i || hard_clr_i) q <= 1'b0;
        else if (set_i)          q <= 1'b1;
        else if (soft_clr_i)     q <= 1'b0;
      end
    end else begin : g_clr_first
      always_ff @(posedge clk_i) begin
        if (rst_i || hard_clr_i) q <= 1'b0;
        else if (soft_clr_i)     q <= 1'b0;
        else if (set_i)          q <= 1'b1;
      end
    end
  endgenerate

  assign q_o = q;

  // R8: a hard clear always leaves the flag at zero
  p_hard_clr_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    hard_clr_i |=> !q_o);
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              start_gen_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              arb_lost_i,
  input  logic              bit8_rise_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              rel_i,
  input  logic              rd_i,
  input  logic [LIVE_W-1:0] live_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam int NIB_HI = ADDR_W - 1;
  localparam int NIB_LO = ADDR_W - NIB_W;

  // Named internal events
  logic en_fall;
  logic off_clr;
  logic ext_hit;
  logic mst_set, mst_clr;
  logic exc_set, exc_clr;
  logic msts, ald, exc;

  stat_en_edge u_edge (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .en_fall_o(en_fall)
  );

  assign off_clr = ~en_i | en_fall;
  assign ext_hit = is_ext_nibble(rx_addr_i[NIB_HI:NIB_LO]);
  assign mst_set = start_gen_i;
  assign mst_clr = stop_det_i | arb_lost_i | rel_i;
  assign exc_set = bit8_rise_i & ext_hit;
  assign exc_clr = start_det_i | stop_det_i | rel_i;

  stat_sticky #(.SET_BEATS_SOFT(1'b0)) u_mst (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(mst_set),
    .soft_clr_i(mst_clr), .hard_clr_i(off_clr), .q_o(msts)
  );

  stat_sticky #(.SET_BEATS_SOFT(1'b1)) u_arb (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(arb_lost_i),
    .soft_clr_i(rd_i), .hard_clr_i(off_clr), .q_o(ald)
  );

  stat_sticky #(.SET_BEATS_SOFT(1'b0)) u_ext (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(exc_set),
    .soft_clr_i(exc_clr), .hard_clr_i(off_clr), .q_o(exc)
  );

  always_comb begin
    stat_o          = '0;
    stat_o[BIT_MST] = msts;
    stat_o[BIT_ARB] = ald;
    stat_o[BIT_EXT] = exc;
    stat_o[LIVE_W-1:0] = live_i;
  end

  // R2: an uncontested start makes the controller master
  p_mst_set_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && start_gen_i && !stop_det_i && !arb_lost_i && !rel_i) |=> stat_o[BIT_MST]);

  // R3: any master clear event wins
  p_mst_clr_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (stop_det_i || rel_i) |=> !stat_o[BIT_MST]);

  // R4: arbitration loss sets the flag and drops master status together
  p_arb_set_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && arb_lost_i) |=> (stat_o[BIT_ARB] && !stat_o[BIT_MST]));

  // R5: a read with no new loss clears the flag one edge later
  p_arb_rdclr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && !arb_lost_i) |=> !stat_o[BIT_ARB]);

  // R6: a reserved nibble on the eighth clock sets the flag
  p_ext_set_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && bit8_rise_i && ext_hit && !start_det_i && !stop_det_i && !rel_i)
      |=> stat_o[BIT_EXT]);

  // R6: a non-reserved nibble never raises the flag
  p_ext_nohit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!stat_o[BIT_EXT] && !(bit8_rise_i && ext_hit)) |=> !stat_o[BIT_EXT]);

  // R7: bus start/stop or release clear the extension flag
  p_ext_clr_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    exc_clr |=> !stat_o[BIT_EXT]);

  // R8: a low enable forces all held flags to zero
  p_off_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (stat_o[BIT_MST:BIT_EXT] == 3'b000));
endmodule

// File: tb/tb_i2c_stat_reg.sv
module tb_i2c_stat_reg;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;
  localparam int WATCHDOG = 50000;

  logic       clk = 1'b0;
  logic       rst, en, start_gen, start_det, stop_det, arb_lost, bit8, rel, rd;
  logic [7:0] addr;
  logic [4:0] live;
  logic [7:0] stat;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Bench model of held flags
  logic m_mst = 1'b0, m_arb = 1'b0, m_ext = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_reg dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .start_gen_i(start_gen),
    .start_det_i(start_det), .stop_det_i(stop_det), .arb_lost_i(arb_lost),
    .bit8_rise_i(bit8), .rx_addr_i(addr), .rel_i(rel), .rd_i(rd),
    .live_i(live), .stat_o(stat)
  );

  function automatic logic reserved(input logic [7:0] a);
    return (&a[7:4]) | ~(|a[7:4]);
  endfunction

  function automatic logic nx_mst(input logic cur);
    if (rst || !en) return 1'b0;
    if (stop_det || arb_lost || rel) return 1'b0;
    if (start_gen) return 1'b1;
    return cur;
  endfunction

  function automatic logic nx_arb(input logic cur);
    if (rst || !en) return 1'b0;
    if (arb_lost) return 1'b1;
    if (rd) return 1'b0;
    return cur;
  endfunction

  function automatic logic nx_ext(input logic cur);
    if (rst || !en) return 1'b0;
    if (start_det || stop_det || rel) return 1'b0;
    if (bit8 && reserved(addr)) return 1'b1;
    return cur;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic idle();
    start_gen = 0; start_det = 0; stop_det = 0; arb_lost = 0;
    bit8 = 0; rel = 0; rd = 0;
  endtask

  // Advance one edge with the inputs now driven, then compare model
  task automatic tick();
    m_mst = nx_mst(m_mst);
    m_arb = nx_arb(m_arb);
    m_ext = nx_ext(m_ext);
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check("R2/R3/R4 master-busy", {7'd0, stat[7]}, {7'd0, m_mst});
    check("R4/R5 arbitration-lost", {7'd0, stat[6]}, {7'd0, m_arb});
    check("R6/R7 extension-code", {7'd0, stat[5]}, {7'd0, m_ext});
    check("R9 live pass", {3'd0, stat[4:0]}, {3'd0, live});
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle();
    rst = 1; en = 0; addr = 8'h00; live = 5'h00;
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    tick();
    check("R1 reset value", stat, 8'h00);
    en = 1;
    tick();

    // R2 start sets master
    start_gen = 1; tick(); idle();
    check("R2 master set", stat, 8'h80);

    // R3 start plus stop: clear wins
    rel = 1; tick(); idle();
    start_gen = 1; stop_det = 1; tick(); idle();
    check("R3 clear beats set", stat, 8'h00);

    // R4 loss sets flag and drops master
    start_gen = 1; tick(); idle();
    arb_lost = 1; tick(); idle();
    check("R4 loss drops master", stat, 8'h40);

    // R5 read returns flag, then clears
    rd = 1; #1;
    check("R5 read data shows flag", {7'd0, stat[6]}, 8'h01);
    tick(); idle();
    check("R5 cleared after read", {7'd0, stat[6]}, 8'h00);

    // R5 read with new loss keeps flag
    arb_lost = 1; tick(); idle();
    arb_lost = 1; rd = 1; tick(); idle();
    check("R5 loss beats read", {7'd0, stat[6]}, 8'h01);
    rd = 1; tick(); idle();

    // R6 nibble decode
    bit8 = 1; addr = 8'h0A; tick(); idle();
    check("R6 nibble 0000 sets", {7'd0, stat[5]}, 8'h01);
    start_det = 1; tick(); idle();
    check("R7 start clears ext", {7'd0, stat[5]}, 8'h00);
    bit8 = 1; addr = 8'hF3; tick(); idle();
    check("R6 nibble 1111 sets", {7'd0, stat[5]}, 8'h01);
    stop_det = 1; tick(); idle();
    bit8 = 1; addr = 8'h5F; tick(); idle();
    check("R6 other nibble ignored", {7'd0, stat[5]}, 8'h00);
    bit8 = 1; addr = 8'h00; rel = 1; tick(); idle();
    check("R7 clear beats set", {7'd0, stat[5]}, 8'h00);

    // R8 disable clears and holds
    start_gen = 1; arb_lost = 0; tick(); idle();
    arb_lost = 1; tick(); idle();
    bit8 = 1; addr = 8'hF0; tick(); idle();
    en = 0; tick();
    check("R8 fall clears held flags", {5'd0, stat[7:5]}, 8'h00);
    start_gen = 1; arb_lost = 1; bit8 = 1; addr = 8'h00; tick(); idle();
    check("R8 held low while disabled", {5'd0, stat[7:5]}, 8'h00);
    en = 1; tick();

    // R9 live pass-through
    live = 5'h15; #1;
    check("R9 live same cycle", {3'd0, stat[4:0]}, 8'h15);

    // Random phase
    for (int i = 0; i < RAND_CYCLES; i++) begin
      en        = ($urandom % 40) != 0;
      start_gen = ($urandom % 6) == 0;
      start_det = ($urandom % 8) == 0;
      stop_det  = ($urandom % 8) == 0;
      arb_lost  = ($urandom % 7) == 0;
      bit8      = ($urandom % 4) == 0;
      rel       = ($urandom % 12) == 0;
      rd        = ($urandom % 3) == 0;
      addr      = (($urandom % 2) == 0) ? {($urandom % 2) ? 4'hF : 4'h0, 4'($urandom)}
                                        : 8'($urandom);
      live      = 5'($urandom);
      tick();
    end
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule